// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block keeps time of day and calendar date in packed BCD fields and advances them by one second for every 64 pulses on its tick input. A prescaler divides the tick into seconds. A stop bit in the control register holds that prescaler at zero, so software can line up the second boundary. Seconds carry into minutes, minutes into hours, and hours into the day of month and the weekday. The day carries into the month, and the month carries into the year. When the year wraps, a century bit toggles. February gets a 29th day in every year whose value divides by four, and year 00 counts as one of those years.

The host reaches the fields through a byte-wide register port with a 4-bit pointer. The host loads the pointer once. After that, every read or write strobe steps the pointer by one. While the host holds `freeze` high for a read session, the counters do not move, so a multi-byte read returns one coherent time. A second that falls due during the freeze is held and applied once `freeze` drops. A write cycle defers the increment in the same way. A low-supply input sets a sticky flag in the top bit of the seconds register, and only a write clears it.

Register layout:
- Address 0: seconds, with the flag in bit 7.
- Address 1: minutes.
- Address 2: hours.
- Address 3: day of month.
- Address 4: weekday.
- Address 5: month, with the century bit in bit 7.
- Address 6: year.
- Address 7: control, with the stop bit in bit 0.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read as follows: seconds 0x80 (flag set, 00 s), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 (century 0), year 0x00, control 0x00.
- R2: Seconds (address 0, bits 6:0) and minutes (address 1) count 00 to 59 in BCD and wrap to 00 with a carry. Hours (address 2) count 00 to 23 and wrap to 00, carrying into the day.
- R3: The weekday (address 4) is plain binary 0 to 6. It wraps from 6 to 0 and advances in the same cycle as the day of month.
- R4: The day (address 3) wraps to 01 after the last day of its month: 30 for April, June, September and November, 31 for the other months apart from February. The wrap carries into the month. The month (address 5, bits 4:0) wraps from 12 to 01 and carries into the year (address 6, 00 to 99 BCD).
- R5: February has 29 days when the year value divides by 4, year 00 included, and 28 days otherwise.
- R6: The century bit (address 5, bit 7) toggles when the year wraps from 99 to 00.
- R7: With stop clear, one second is added for every 64 tick pulses.
- R8: While the stop bit (address 7, bit 0) is 1, the prescaler is held at zero. After the bit clears, the first second is added on the 32nd tick, and each later second on every further 64th tick.
- R9: While `freeze` is high the time fields do not change. A second that falls due during the freeze is applied in the cycle after `freeze` falls, and no second is lost.
- R10: `vlow` sets bit 7 of address 0. The bit stays set until a write to address 0 puts 0 there.
- R11: `addr_load` sets the pointer. Each read or write strobe then steps it by one, wrapping from 15 to 0. Addresses 8 to 15 read 0x00, and writes to them change nothing.
- R12: A write stores only the implemented bits of its field: weekday bits 2:0; month bits 4:0 plus the century bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at the 64 Hz rate |
| freeze | input | 1 | Read session active; holds the counters |
| vlow | input | 1 | Supply-low indication; sets the sticky flag |
| addr_load | input | 1 | Load the pointer from addr_in |
| addr_in | input | 4 | New pointer value |
| rd_en | input | 1 | Read strobe; steps the pointer |
| wr_en | input | 1 | Write strobe; writes wr_data at the pointer, then steps it |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register at the current pointer |

## Verification
The assertions assume that every value written into a time field is a legal BCD value within that field's range. They also assume that a freeze or write never lasts long enough for a second second to fall due while one is already held. The stimulus loads only legal dates and times. It keeps each freeze shorter than 64 ticks and never issues a write and a pointer load in the same cycle. Each corner case is reached by loading a time a moment before the rollover and then restarting the prescaler with the stop bit, so the bench knows exactly which tick brings the next second.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int PRE_W = 6,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          freeze,
  input  logic          vlow,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data
);
  localparam logic [PRE_W-1:0] FIRE_AT = PRE_W'((1 << (PRE_W - 1)) - 1);
  localparam logic [AW-1:0] A_SEC = AW'(0);
  localparam logic [AW-1:0] A_MIN = AW'(1);
  localparam logic [AW-1:0] A_HR  = AW'(2);
  localparam logic [AW-1:0] A_DAY = AW'(3);
  localparam logic [AW-1:0] A_WD  = AW'(4);
  localparam logic [AW-1:0] A_MON = AW'(5);
  localparam logic [AW-1:0] A_YR  = AW'(6);
  localparam logic [AW-1:0] A_CTL = AW'(7);

  logic [7:0] sec_q, min_q, hr_q, day_q, wd_q, mon_q, yr_q;
  logic vl_q, cen_q, stop_q, pend_q;
  logic [PRE_W-1:0] pre_q;
  logic [AW-1:0] ptr_q;

  function automatic logic [7:0] binc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic leap;
  logic [7:0] last_day;
  assign leap = yr_q[4] ? (yr_q[3:0] == 4'd2 || yr_q[3:0] == 4'd6)
                        : (yr_q[3:0] == 4'd0 || yr_q[3:0] == 4'd4 || yr_q[3:0] == 4'd8);

  always_comb begin
    case (mon_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  logic sec_evt, req, hold, go;
  logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;
  assign sec_evt = tick & ~stop_q & (pre_q == FIRE_AT);
  assign req     = sec_evt | pend_q;
  assign hold    = freeze | wr_en;
  assign go      = req & ~hold;
  assign c_min   = go    & (sec_q == 8'h59);
  assign c_hr    = c_min & (min_q == 8'h59);
  assign c_day   = c_hr  & (hr_q  == 8'h23);
  assign c_mon   = c_day & (day_q == last_day);
  assign c_yr    = c_mon & (mon_q == 8'h12);
  assign c_cen   = c_yr  & (yr_q  == 8'h99);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      vl_q   <= 1'b1;
      min_q  <= 8'h00;
      hr_q   <= 8'h00;
      day_q  <= 8'h01;
      wd_q   <= 8'h00;
      mon_q  <= 8'h01;
      cen_q  <= 1'b0;
      yr_q   <= 8'h00;
      stop_q <= 1'b0;
      pre_q  <= '0;
      pend_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (stop_q)    pre_q <= '0;
      else if (tick) pre_q <= pre_q + PRE_W'(1);
      pend_q <= req & hold;

      if (go)    sec_q <= (sec_q == 8'h59) ? 8'h00 : binc(sec_q);
      if (c_min) min_q <= (min_q == 8'h59) ? 8'h00 : binc(min_q);
      if (c_hr)  hr_q  <= (hr_q  == 8'h23) ? 8'h00 : binc(hr_q);
      if (c_day) begin
        day_q <= (day_q == last_day) ? 8'h01 : binc(day_q);
        wd_q  <= (wd_q == 8'd6) ? 8'd0 : wd_q + 8'd1;
      end
      if (c_mon) mon_q <= (mon_q == 8'h12) ? 8'h01 : binc(mon_q);
      if (c_yr)  yr_q  <= (yr_q  == 8'h99) ? 8'h00 : binc(yr_q);
      if (c_cen) cen_q <= ~cen_q;

      if (wr_en) begin
        case (ptr_q)
          A_SEC: begin sec_q <= wr_data & 8'h7F; vl_q <= wr_data[7]; end
          A_MIN: min_q <= wr_data & 8'h7F;
          A_HR:  hr_q  <= wr_data & 8'h3F;
          A_DAY: day_q <= wr_data & 8'h3F;
          A_WD:  wd_q  <= wr_data & 8'h07;
          A_MON: begin mon_q <= wr_data & 8'h1F; cen_q <= wr_data[7]; end
          A_YR:  yr_q  <= wr_data;
          A_CTL: stop_q <= wr_data[0];
          default: ;
        endcase
      end
      if (vlow) vl_q <= 1'b1;

      if (addr_load)            ptr_q <= addr_in;
      else if (rd_en || wr_en)  ptr_q <= ptr_q + AW'(1);
    end
  end

  always_comb begin
    case (ptr_q)
      A_SEC:   rd_data = {vl_q, 7'd0} | sec_q;
      A_MIN:   rd_data = min_q;
      A_HR:    rd_data = hr_q;
      A_DAY:   rd_data = day_q;
      A_WD:    rd_data = wd_q;
      A_MON:   rd_data = {cen_q, 7'd0} | mon_q;
      A_YR:    rd_data = yr_q;
      A_CTL:   rd_data = {7'd0, stop_q};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk #(
  parameter int PRE_W = 6,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             freeze,
  input logic             wr_en,
  input logic             rd_en,
  input logic             addr_load,
  input logic [AW-1:0]    ptr_q,
  input logic             vl_q,
  input logic             stop_q,
  input logic [PRE_W-1:0] pre_q,
  input logic [7:0]       sec_q,
  input logic [7:0]       min_q,
  input logic [7:0]       hr_q,
  input logic [7:0]       day_q,
  input logic [7:0]       wd_q,
  input logic [7:0]       mon_q,
  input logic             cen_q,
  input logic [7:0]       yr_q
);
  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable({sec_q, min_q, hr_q, day_q, wd_q, mon_q, cen_q, yr_q}));

  // R10
  vl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_q && !(wr_en && ptr_q == AW'(0))) |=> vl_q);

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> (pre_q == '0));

  // R3
  weekday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_q <= 8'd6);

  // R2
  sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q[3:0] <= 4'd9) && (sec_q <= 8'h59));

  // R11
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !addr_load) |=> (ptr_q == $past(ptr_q) + AW'(1)));
endmodule

bind bcd_calendar bcd_calendar_chk #(.PRE_W(PRE_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr_en(wr_en), .rd_en(rd_en),
  .addr_load(addr_load), .ptr_q(ptr_q), .vl_q(vl_q), .stop_q(stop_q),
  .pre_q(pre_q), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .day_q(day_q),
  .wd_q(wd_q), .mon_q(mon_q), .cen_q(cen_q), .yr_q(yr_q)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, freeze = 0, vlow = 0;
  logic addr_load = 0, rd_en = 0, wr_en = 0;
  logic [3:0] addr_in = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  bcd_calendar u_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze), .vlow(vlow),
    .addr_load(addr_load), .addr_in(addr_in), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural reference model (binary integers)
  int m_sec, m_min, m_hr, m_day, m_wd, m_mon, m_yr, m_cen, m_vl, m_stop, m_pre, m_pend, m_ptr;

  function automatic int b2i(input logic [7:0] d);
    return int'(d[7:4]) * 10 + int'(d[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] mval(input int a);
    case (a)
      0: return (m_vl ? 8'h80 : 8'h00) | i2b(m_sec);
      1: return i2b(m_min);
      2: return i2b(m_hr);
      3: return i2b(m_day);
      4: return 8'(m_wd);
      5: return (m_cen ? 8'h80 : 8'h00) | i2b(m_mon);
      6: return i2b(m_yr);
      7: return 8'(m_stop);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagof(input int a);
    case (a)
      0, 1, 2: return "R2";
      3: return "R4";
      4: return "R3";
      5: return "R6";
      6: return "R5";
      7: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic advance();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
          if (m_day > days_in(m_mon, m_yr)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_yr++;
              if (m_yr == 100) begin m_yr = 0; m_cen ^= 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    case (a)
      0: begin m_sec = b2i(d & 8'h7F); m_vl = d[7]; end
      1: m_min = b2i(d & 8'h7F);
      2: m_hr = b2i(d & 8'h3F);
      3: m_day = b2i(d & 8'h3F);
      4: m_wd = int'(d & 8'h07);
      5: begin m_mon = b2i(d & 8'h1F); m_cen = d[7]; end
      6: m_yr = b2i(d);
      7: m_stop = d[0];
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    bit evt, req, hold;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_wd = 0; m_mon = 1; m_yr = 0;
      m_cen = 0; m_vl = 1; m_stop = 0; m_pre = 0; m_pend = 0; m_ptr = 0;
    end else begin
      evt = tick && !m_stop && m_pre == 31;
      if (m_stop) m_pre = 0;
      else if (tick) m_pre = (m_pre + 1) % 64;
      req = evt || m_pend;
      hold = freeze || wr_en;
      if (req && !hold) advance();
      m_pend = req && hold;
      if (wr_en) model_write(m_ptr, wr_data);
      if (vlow) m_vl = 1;
      if (addr_load) m_ptr = int'(addr_in);
      else if (rd_en || wr_en) m_ptr = (m_ptr + 1) % 16;
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== mval(m_ptr)) begin
        fails++;
        $display("FAIL %s model compare addr %0d: actual %h expected %h",
                 tagof(m_ptr), m_ptr, rd_data, mval(m_ptr));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL R7 watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic set_ptr(input logic [3:0] a);
    @(negedge clk) begin addr_load = 1; addr_in = a; end
    @(negedge clk) addr_load = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string tag);
    @(negedge clk) begin
      checks++;
      if (rd_data !== exp) begin
        fails++;
        $display("FAIL %s directed read: actual %h expected %h", tag, rd_data, exp);
      end
      rd_en = 1;
    end
    @(negedge clk) rd_en = 0;
  endtask

  task automatic restart();
    set_ptr(4'd7); wr(8'h01);
    set_ptr(4'd7); wr(8'h00);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, w, mo, y);
    set_ptr(4'd0);
    wr(s); wr(m); wr(h); wr(d); wr(w); wr(mo); wr(y);
  endtask

  task automatic chk_time(input logic [7:0] s, m, h, d, w, mo, y, input string tag);
    set_ptr(4'd0);
    rd_chk(s, tag); rd_chk(m, tag); rd_chk(h, tag); rd_chk(d, tag);
    rd_chk(w, tag); rd_chk(mo, tag); rd_chk(y, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk_time(8'h80, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, "R1");
    rd_chk(8'h00, "R1");
    rd_chk(8'h00, "R11");

    // R2 R3 R4: non-leap February end, weekday 6 wraps to 0
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h03);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h03, 8'h03, "R4");

    // R5 leap year 04
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h04);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h03, 8'h02, 8'h04, "R5");
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h03, 8'h02, 8'h04);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h04, 8'h03, 8'h04, "R5");

    // R5 year 00 is leap
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h00, 8'h02, 8'h00);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h01, 8'h02, 8'h00, "R5");

    // R4 30-day month and January end
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h04, 8'h21);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h05, 8'h21, "R4");
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h01, 8'h21);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 8'h02, 8'h21, "R4");

    // R6 year wrap toggles century both ways
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h04, 8'h12, 8'h99);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h81, 8'h00, "R6");
    restart();
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h04, 8'h92, 8'h99);
    ticks(32);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h01, 8'h00, "R6");

    // R7 R8: 32 ticks after stop clears, then every 64
    restart();
    set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    ticks(31);
    set_ptr(4'd0); rd_chk(8'h00, "R8");
    ticks(1);
    set_ptr(4'd0); rd_chk(8'h01, "R8");
    ticks(63);
    set_ptr(4'd0); rd_chk(8'h01, "R7");
    ticks(1);
    set_ptr(4'd0); rd_chk(8'h02, "R7");
    // R8 stop held: no seconds
    set_ptr(4'd7); wr(8'h01);
    ticks(100);
    set_ptr(4'd0); rd_chk(8'h02, "R8");
    set_ptr(4'd7); rd_chk(8'h01, "R8");

    // R9 freeze defers one second, none lost
    restart();
    set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
    ticks(31);
    @(negedge clk) freeze = 1;
    ticks(1);
    set_ptr(4'd0); rd_chk(8'h10, "R9");
    ticks(5);
    set_ptr(4'd0); rd_chk(8'h10, "R9");
    @(negedge clk) freeze = 0;
    @(negedge clk);
    set_ptr(4'd0); rd_chk(8'h11, "R9");
    ticks(58);
    set_ptr(4'd0); rd_chk(8'h11, "R9");
    ticks(1);
    set_ptr(4'd0); rd_chk(8'h12, "R9");

    // R10 sticky voltage-low flag
    @(negedge clk) vlow = 1;
    @(negedge clk) vlow = 0;
    set_ptr(4'd1); wr(8'h07);
    set_ptr(4'd0); rd_chk(8'h92, "R10");
    set_ptr(4'd0); wr(8'h05);
    set_ptr(4'd0); rd_chk(8'h05, "R10");

    // R11 pointer wrap, unused addresses
    set_ptr(4'd10); wr(8'hFF);
    set_ptr(4'd10); rd_chk(8'h00, "R11");
    set_ptr(4'd15); rd_chk(8'h00, "R11");
    rd_chk(8'h05, "R11");
    rd_chk(8'h07, "R11");

    // R12 masked writes
    set_ptr(4'd4); wr(8'hF3); wr(8'h72);
    set_ptr(4'd4); rd_chk(8'h03, "R12"); rd_chk(8'h12, "R12");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule